// File: doc/BRIEF.md
# Temporary Bus Master Claim Controller

This block sits on a local processor card whose processor sometimes has to reach the shared backplane instead of its own memory. It looks at the address and status of each local processor cycle and decides whether the cycle must go off-card. Off-card cycles are memory accesses at or above a parameterised base address (0xC000 by default) and every I/O port access, because the card has no ports of its own. Interrupt-acknowledge cycles never go off-card. While an off-card cycle is waiting, the block drives the processor's ready input low so the processor stalls.

When the processor strobe rises with the off-card decision still present, the block records a pending request. As soon as the shared hold line and the hold acknowledge are both idle, it raises its priority claim. In the same cycle it pulls the active-low hold line, which both enables the external priority arbitration cell and keeps other cards from starting a claim. When hold acknowledge arrives, the external winner input settles the claim. A losing card drops the claim, keeps its request and tries again once the bus is idle. A winning card owns the bus and signals the start of the transfer on the next falling edge of the bus clock. When the transfer finishes, the block releases everything and lets the processor continue.

Top module: `tmreq_top`

## Requirements
- R1: One clock edge after a valid status shows a memory address at or above 0xC000, or an I/O access (`cpu_io`=1), `cpu_ready` is 0. A memory address below 0xC000, or `cpu_stat_vld`=0, leaves `cpu_ready` at 1.
- R2: A status with `cpu_inta`=1 is never treated as off-card, even with `cpu_io`=1 or a high address. `cpu_ready` stays 1.
- R3: `cpu_ready` is 0 whenever an off-card decision, a pending request or a priority claim is present.
- R4: A request is recorded only on a rising edge of `cpu_strobe` that is seen while the registered off-card decision is still 1. If the decision has dropped before the strobe rises, no claim ever follows and `cpu_ready` returns to 1.
- R5: A pending request raises `prio_en` on the next edge only if `hold_n_in`=1 and `hlda`=0. While either is busy, `prio_en` stays 0 and the request stays pending.
- R6: `hold_n_out` is 0 in exactly the cycles where `prio_en` is 1.
- R7: If `hlda`=1 and `win`=0 while the claim is up, the next edge clears `prio_en` and releases `hold_n_out`. The request and the stall are kept, and the claim is raised again once the bus is idle.
- R8: If `hlda`=1 and `win`=1 while the claim is up, `bus_owner` is 1 from the next edge on.
- R9: After ownership begins, `xfer_start` pulses for exactly one cycle after the first falling edge of `bus_clk` that passes through the synchroniser. It pulses only while `bus_owner` is 1.
- R10: `xfer_done` after the start pulse clears `bus_owner`, `prio_en` and the request on the next edge, sets `hold_n_out` to 1 and `cpu_ready` to 1. No new request is taken until `cpu_strobe` has fallen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Local processor address |
| cpu_io | input | 1 | Status: I/O port cycle |
| cpu_inta | input | 1 | Status: interrupt-acknowledge cycle |
| cpu_stat_vld | input | 1 | Address and status are valid |
| cpu_strobe | input | 1 | Processor read/write strobe, active high |
| hold_n_in | input | 1 | Shared hold line as seen on the bus, active low |
| hlda | input | 1 | Hold acknowledge from the permanent master |
| win | input | 1 | Winner result from the arbitration cell |
| bus_clk | input | 1 | Backplane clock, asynchronous to clk |
| xfer_done | input | 1 | Transfer sequencer reports completion |
| cpu_ready | output | 1 | Ready to the local processor, 0 stalls it |
| prio_en | output | 1 | Priority claim, enables the arbitration cell |
| hold_n_out | output | 1 | Hold request drive, active low |
| bus_owner | output | 1 | Card owns the backplane |
| xfer_start | output | 1 | One-cycle pulse that begins the transfer |

## Verification
Every output is a register. `cpu_ready` follows a new status one edge later. The request follows the strobe's rising edge by one edge, and `prio_en` with `hold_n_out` follows the request by one more edge. `bus_owner` and a dropped claim follow the edge on which `hlda` is sampled by one edge, and completion clears everything one edge after `xfer_done`. The bench drives inputs on the falling clock edge and reads outputs on the falling edge after exactly that many rising edges. The bus master model adds its own two-edge delay before `hlda`, and the bus clock passes through a synchroniser, so for ownership, the retry and `xfer_start` the bench polls on falling edges within a bounded window and then checks the pulse width and the state around it exactly.

// File: rtl/tmreq_pkg.sv
package tmreq_pkg;
  typedef enum logic [1:0] {
    CL_IDLE = 2'd0,
    CL_PEND = 2'd1,
    CL_PRIO = 2'd2,
    CL_OWN  = 2'd3
  } claim_t;
endpackage

// File: rtl/tmreq_decode.sv
module tmreq_decode #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] EXT_BASE = 16'hC000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              io,
  input  logic              inta,
  input  logic              vld,
  output logic              ext_now,
  output logic              ext_q
);
  logic hi_mem;

  // memory window at or above the base, or any port cycle; never for an acknowledge
  assign hi_mem  = (addr >= EXT_BASE);
  assign ext_now = vld && !inta && (io || hi_mem);

  always_ff @(posedge clk) begin
    if (rst) ext_q <= 1'b0;
    else     ext_q <= ext_now;
  end
endmodule

// File: rtl/tmreq_sync.sv
module tmreq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= 1'b0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/tmreq_claim.sv
module tmreq_claim
  import tmreq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ext_now,
  input  logic ext_q,
  input  logic strobe,
  input  logic hold_n_in,
  input  logic hlda,
  input  logic win,
  input  logic bclk_s,
  input  logic xfer_done,
  output logic cpu_ready,
  output logic prio_en,
  output logic hold_n_out,
  output logic bus_owner,
  output logic xfer_start
);
  claim_t st, st_n;
  logic   strobe_q, bclk_p;
  logic   served, served_n;
  logic   started, started_n;
  logic   strobe_rise, strobe_fall, bclk_fall;
  logic   done_ok, prio_n, start_n;

  assign strobe_rise = strobe && !strobe_q;
  assign strobe_fall = !strobe && strobe_q;
  assign bclk_fall   = bclk_p && !bclk_s;
  assign done_ok     = (st == CL_OWN) && started && xfer_done;

  always_comb begin
    st_n = st;
    unique case (st)
      CL_IDLE: if (strobe_rise && ext_q && !served) st_n = CL_PEND;
      CL_PEND: if (hold_n_in && !hlda)              st_n = CL_PRIO;
      CL_PRIO: if (hlda)                            st_n = win ? CL_OWN : CL_PEND;
      CL_OWN:  if (done_ok)                         st_n = CL_IDLE;
      default:                                      st_n = CL_IDLE;
    endcase
  end

  always_comb begin
    served_n = served;
    if (done_ok)          served_n = 1'b1;
    else if (strobe_fall) served_n = 1'b0;
  end

  assign start_n   = (st == CL_OWN) && !started && bclk_fall;
  assign started_n = (st_n == CL_OWN) && (started || start_n);
  assign prio_n    = (st_n == CL_PRIO) || (st_n == CL_OWN);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= CL_IDLE;
      strobe_q   <= 1'b0;
      bclk_p     <= 1'b0;
      served     <= 1'b0;
      started    <= 1'b0;
      cpu_ready  <= 1'b1;
      prio_en    <= 1'b0;
      hold_n_out <= 1'b1;
      bus_owner  <= 1'b0;
      xfer_start <= 1'b0;
    end else begin
      st         <= st_n;
      strobe_q   <= strobe;
      bclk_p     <= bclk_s;
      served     <= served_n;
      started    <= started_n;
      cpu_ready  <= !((ext_now && !served_n) || (st_n != CL_IDLE));
      prio_en    <= prio_n;
      hold_n_out <= !prio_n;
      bus_owner  <= (st_n == CL_OWN);
      xfer_start <= start_n;
    end
  end
endmodule

// File: rtl/tmreq_top.sv
module tmreq_top #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] EXT_BASE = 16'hC000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_io,
  input  logic              cpu_inta,
  input  logic              cpu_stat_vld,
  input  logic              cpu_strobe,
  input  logic              hold_n_in,
  input  logic              hlda,
  input  logic              win,
  input  logic              bus_clk,
  input  logic              xfer_done,
  output logic              cpu_ready,
  output logic              prio_en,
  output logic              hold_n_out,
  output logic              bus_owner,
  output logic              xfer_start
);
  logic ext_now, ext_q, bclk_s;

  tmreq_decode #(.ADDR_W(ADDR_W), .EXT_BASE(EXT_BASE)) u_dec (
    .clk(clk), .rst(rst), .addr(cpu_addr), .io(cpu_io), .inta(cpu_inta),
    .vld(cpu_stat_vld), .ext_now(ext_now), .ext_q(ext_q)
  );

  tmreq_sync #(.STAGES(SYNC_STAGES)) u_bsync (
    .clk(clk), .rst(rst), .d(bus_clk), .q(bclk_s)
  );

  tmreq_claim u_claim (
    .clk(clk), .rst(rst), .ext_now(ext_now), .ext_q(ext_q), .strobe(cpu_strobe),
    .hold_n_in(hold_n_in), .hlda(hlda), .win(win), .bclk_s(bclk_s),
    .xfer_done(xfer_done), .cpu_ready(cpu_ready), .prio_en(prio_en),
    .hold_n_out(hold_n_out), .bus_owner(bus_owner), .xfer_start(xfer_start)
  );
endmodule

// File: rtl/tmreq_chk.sv
module tmreq_chk (
  input logic clk,
  input logic rst,
  input logic hold_n_in,
  input logic hlda,
  input logic win,
  input logic cpu_ready,
  input logic prio_en,
  input logic hold_n_out,
  input logic bus_owner,
  input logic xfer_start
);
  // R3
  ready_low_chk: assert property (@(posedge clk) disable iff (rst)
    prio_en |-> !cpu_ready);

  // R5
  prio_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(prio_en) |-> ($past(hold_n_in) && !$past(hlda)));

  // R6
  hold_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (prio_en && !hold_n_out) || (!prio_en && hold_n_out));

  // R7
  lose_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (prio_en && hlda && !win && !bus_owner) |=> (!prio_en && !cpu_ready));

  // R8
  win_own_chk: assert property (@(posedge clk) disable iff (rst)
    (prio_en && hlda && win && !bus_owner) |=> bus_owner);

  // R9
  start_owner_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_start |-> bus_owner);

  // R9
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_start |=> !xfer_start);
endmodule

bind tmreq_top tmreq_chk u_chk (
  .clk(clk), .rst(rst), .hold_n_in(hold_n_in), .hlda(hlda), .win(win),
  .cpu_ready(cpu_ready), .prio_en(prio_en), .hold_n_out(hold_n_out),
  .bus_owner(bus_owner), .xfer_start(xfer_start)
);

// File: tb/sim_tmreq_top.sv
`timescale 1ns/1ps
module sim_tmreq_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic        cpu_io = 1'b0, cpu_inta = 1'b0, cpu_stat_vld = 1'b0, cpu_strobe = 1'b0;
  logic        hlda = 1'b0, win = 1'b0, bus_clk = 1'b0, xfer_done = 1'b0;
  logic        other_hold_n = 1'b1, hold_seen = 1'b0;
  logic        cpu_ready, prio_en, hold_n_out, bus_owner, xfer_start;
  logic        hold_line;
  int          checks = 0, errors = 0, cyc = 0;

  assign hold_line = hold_n_out && other_hold_n;

  always #2 clk = ~clk;
  always #7 bus_clk = ~bus_clk;

  tmreq_top u0 (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_io(cpu_io), .cpu_inta(cpu_inta),
    .cpu_stat_vld(cpu_stat_vld), .cpu_strobe(cpu_strobe), .hold_n_in(hold_line),
    .hlda(hlda), .win(win), .bus_clk(bus_clk), .xfer_done(xfer_done),
    .cpu_ready(cpu_ready), .prio_en(prio_en), .hold_n_out(hold_n_out),
    .bus_owner(bus_owner), .xfer_start(xfer_start)
  );

  // permanent master: samples hold, acknowledges one clock later
  always @(posedge clk) begin
    if (rst) begin
      hold_seen <= 1'b0;
      hlda      <= 1'b0;
    end else begin
      hold_seen <= !hold_line;
      hlda      <= hold_seen;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected under 50000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // {addr[15:0], io, inta, vld, expected off-card}
  localparam logic [19:0] VEC [8] = '{
    {16'hC000, 1'b0, 1'b0, 1'b1, 1'b1},
    {16'hBFFF, 1'b0, 1'b0, 1'b1, 1'b0},
    {16'hFFFF, 1'b0, 1'b0, 1'b1, 1'b1},
    {16'h0000, 1'b0, 1'b0, 1'b1, 1'b0},
    {16'h0012, 1'b1, 1'b0, 1'b1, 1'b1},
    {16'h0012, 1'b1, 1'b1, 1'b1, 1'b0},
    {16'hF000, 1'b0, 1'b1, 1'b1, 1'b0},
    {16'hC000, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  task automatic finish_xfer(input string tag);
    bit got = 0;
    for (int k = 0; k < 40; k++) begin
      if (!got) begin
        @(negedge clk);
        got = xfer_start;
      end
    end
    // R9 start pulse seen while owning and acknowledged
    chk(got && bus_owner && hlda, {tag, " R9 start"}, int'(got), 1);
    @(negedge clk);
    chk(!xfer_start, {tag, " R9 single pulse"}, int'(xfer_start), 0);
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
    // R10 release one edge after done
    chk(cpu_ready && !bus_owner && !prio_en && hold_n_out, {tag, " R10 release"},
        {cpu_ready, bus_owner, prio_en, hold_n_out}, 4'b1001);
    repeat (4) @(negedge clk);
    chk(!prio_en && cpu_ready, {tag, " R10 no re-request before strobe falls"},
        int'(prio_en), 0);
    cpu_strobe = 1'b0;
    cpu_stat_vld = 1'b0;
    cpu_io = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    bit got;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state
    chk(cpu_ready && hold_n_out && !prio_en && !bus_owner && !xfer_start, "reset",
        {cpu_ready, hold_n_out, prio_en, bus_owner, xfer_start}, 5'b11000);
    rst = 1'b0;

    // R1 / R2 decode table
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      {cpu_addr, cpu_io, cpu_inta, cpu_stat_vld} = VEC[i][19:1];
      @(posedge clk);
      @(negedge clk);
      chk(cpu_ready == !VEC[i][0], VEC[i][2] ? "R2 inta decode" : "R1 decode",
          int'(cpu_ready), int'(!VEC[i][0]));
    end
    cpu_stat_vld = 1'b0;
    cpu_inta = 1'b0;
    cpu_io = 1'b0;
    repeat (2) @(negedge clk);

    // R4: decision gone before the strobe rises
    cpu_addr = 16'hC000;
    cpu_stat_vld = 1'b1;
    @(negedge clk);
    cpu_stat_vld = 1'b0;
    @(negedge clk);
    cpu_strobe = 1'b1;
    repeat (4) @(negedge clk);
    chk(cpu_ready && !prio_en && hold_n_out, "R4 late strobe ignored",
        {cpu_ready, prio_en}, 2'b10);
    cpu_strobe = 1'b0;
    repeat (2) @(negedge clk);

    // winning claim
    cpu_addr = 16'hC400;
    cpu_stat_vld = 1'b1;
    win = 1'b1;
    @(negedge clk);
    chk(!cpu_ready, "R3 stall on decision", int'(cpu_ready), 0);
    cpu_strobe = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    chk(prio_en, "R5 claim on idle bus", int'(prio_en), 1);
    chk(!hold_n_out, "R6 hold with claim", int'(hold_n_out), 0);
    chk(!cpu_ready, "R3 stall while claiming", int'(cpu_ready), 0);
    got = 0;
    for (int k = 0; k < 20; k++) begin
      if (!got) begin
        @(negedge clk);
        got = bus_owner;
      end
    end
    chk(got && prio_en, "R8 ownership", int'(got), 1);
    finish_xfer("win");

    // blocked by another master, then lose, then retry
    other_hold_n = 1'b0;
    repeat (4) @(negedge clk);
    cpu_addr = 16'h0020;
    cpu_io = 1'b1;
    cpu_stat_vld = 1'b1;
    win = 1'b0;
    @(negedge clk);
    cpu_strobe = 1'b1;
    repeat (6) @(negedge clk);
    chk(!prio_en && hold_n_out, "R5 blocked while bus busy", int'(prio_en), 0);
    chk(!cpu_ready, "R3 stall while pending", int'(cpu_ready), 0);
    other_hold_n = 1'b1;
    got = 0;
    for (int k = 0; k < 20; k++) begin
      if (!got) begin
        @(negedge clk);
        got = prio_en;
      end
    end
    chk(got, "R5 claim after bus idles", int'(got), 1);
    other_hold_n = 1'b0;
    got = 0;
    for (int k = 0; k < 20; k++) begin
      if (!got) begin
        @(negedge clk);
        got = hlda;
      end
    end
    @(negedge clk);
    chk(got && !prio_en && hold_n_out, "R7 lost claim dropped",
        {prio_en, hold_n_out}, 2'b01);
    chk(!cpu_ready && !bus_owner, "R7 request kept", int'(cpu_ready), 0);
    win = 1'b1;
    other_hold_n = 1'b1;
    got = 0;
    for (int k = 0; k < 40; k++) begin
      if (!got) begin
        @(negedge clk);
        got = bus_owner;
      end
    end
    chk(got, "R7 retry wins", int'(got), 1);
    finish_xfer("retry");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule